// File: doc/BRIEF.md
# Sideband Transaction Retry Controller

This block sits in front of an engine that runs one sideband transaction at a time. A caller asks for one transfer. The controller then starts the engine, reads back its result code, reply code and returned-byte count, and decides what to do next: finish with success, finish with failure, reissue at once, or reissue after a programmable defer wait. Each retry cause draws on its own budget. A global cap limits the total number of attempts.

Defers get special treatment. The controller keeps a running total of defer time in milliseconds. A native defer adds the caller's polling period to that total, and every defer wait adds its own length. A native defer only ends the transfer when both the defer count and the accumulated time have reached their floors. A bridged-I2C defer arms a flag, and any timeout seen after that flag is set counts as another defer rather than as a timeout. Defer waits are timed with a millisecond tick built from a clock prescaler.

Top module: `sb_retry_ctrl`

## Requirements
- R1: A transfer makes at most MAX_ATTEMPTS engine attempts (default 7). When an attempt asks for a retry or wait and this limit is already reached, the transfer fails.
- R2: Reply 0x0 (ACK) with result 0 (success) completes the transfer, unless it is a read whose returned-byte count differs from the requested length. Such a short read is retried, and the transfer fails on the 7th short read.
- R3: Result 1 (invalid reply) is retried at once, and the transfer fails on the 2nd one.
- R4: Result 2 (timeout), when no bridged defer has been seen in the transfer, is retried at once with no wait, and the transfer fails on the 3rd one.
- R5: Reply 0x2 (native defer) increments the defer count and adds poll_ms to the defer time. The transfer fails if the count is now at least 7 and the time at least 50 ms; otherwise the controller waits defer_ms, adds defer_ms to the time, and retries.
- R6: Reply 0x8 (bridged defer) clears the native defer count, arms the bridged flag and increments its own count. The transfer fails on the 7th one; otherwise the controller waits defer_ms and retries.
- R7: A timeout that arrives after a bridged defer increments the defer count instead of the timeout count. It fails the transfer when that count reaches 7, and otherwise waits defer_ms and retries.
- R8: Every success result clears both the timeout count and the invalid-reply count.
- R9: The following end the transfer at once as a failure: reply 0x1 (NACK), reply 0x4 (bridged NACK), any other reply code, result 3 (disconnect), result 4 (acquire failure), and results 5 to 7.
- R10: A defer wait of defer_ms lasts exactly defer_ms*CLKS_PER_MS clock cycles. A retry with no wait, or with defer_ms of 0, raises eng_start on the cycle right after the engine's done cycle.
- R11: eng_start and xfer_done are single-cycle pulses, and eng_start only occurs while busy. When xfer_done is high, busy is low; xfer_ok gives the outcome and last_reply gives the reply from the latest success result of that transfer (0 if there was none). After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a transfer (taken when idle) |
| req_read | input | 1 | Transfer is a read |
| req_len | input | LEN_W | Requested byte count |
| defer_ms | input | MS_W | Wait inserted after a defer, in ms |
| poll_ms | input | MS_W | Time charged per native defer, in ms |
| busy | output | 1 | Transfer in progress |
| eng_start | output | 1 | Start one engine transaction |
| eng_done | input | 1 | Engine transaction finished |
| eng_result | input | 3 | Engine result code |
| eng_reply | input | 4 | Sink reply code |
| eng_bytes | input | LEN_W | Data bytes returned |
| xfer_done | output | 1 | Transfer finished (pulse) |
| xfer_ok | output | 1 | Transfer outcome |
| last_reply | output | 4 | Reply from the latest success result |

## Verification
Two situations are the hardest to reach from the ports. The first is a timeout that counts toward the defer budget. The second is a native defer count that is cleared by an intervening bridged defer. Both need long scripted sequences that mix reply kinds within one transfer. The bench's engine model pops one scripted response per eng_start, and the instance raises MAX_ATTEMPTS to 10 so that the per-cause limits can be seen apart from the global cap. For example, four timeouts after one bridged defer still succeed, and eight native defers spread around a bridged defer still succeed on the tenth attempt. Wait lengths are checked by counting busy cycles against 3 per attempt plus CLKS_PER_MS per waited millisecond.

// File: rtl/sb_retry_ctrl.sv
module sb_retry_ctrl #(
  parameter int LEN_W           = 5,
  parameter int MS_W            = 8,
  parameter int TIME_W          = 12,
  parameter int MAX_ATTEMPTS    = 7,
  parameter int SHORT_ACK_LIMIT = 7,
  parameter int INVALID_LIMIT   = 2,
  parameter int TIMEOUT_LIMIT   = 3,
  parameter int DEFER_LIMIT     = 7,
  parameter int BR_DEFER_LIMIT  = 7,
  parameter int DEFER_MS_FLOOR  = 50,
  parameter int CLKS_PER_MS     = 50000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_read,
  input  logic [LEN_W-1:0] req_len,
  input  logic [MS_W-1:0]  defer_ms,
  input  logic [MS_W-1:0]  poll_ms,
  output logic             busy,
  output logic             eng_start,
  input  logic             eng_done,
  input  logic [2:0]       eng_result,
  input  logic [3:0]       eng_reply,
  input  logic [LEN_W-1:0] eng_bytes,
  output logic             xfer_done,
  output logic             xfer_ok,
  output logic [3:0]       last_reply
);

  localparam int M1 = (MAX_ATTEMPTS > SHORT_ACK_LIMIT) ? MAX_ATTEMPTS : SHORT_ACK_LIMIT;
  localparam int M2 = (M1 > INVALID_LIMIT) ? M1 : INVALID_LIMIT;
  localparam int M3 = (M2 > TIMEOUT_LIMIT) ? M2 : TIMEOUT_LIMIT;
  localparam int M4 = (M3 > DEFER_LIMIT) ? M3 : DEFER_LIMIT;
  localparam int LIM_MAX = (M4 > BR_DEFER_LIMIT) ? M4 : BR_DEFER_LIMIT;
  localparam int CW = $clog2(LIM_MAX + 2);
  localparam int PRE_W = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;

  localparam logic [CW-1:0] ATT_LIM = CW'(MAX_ATTEMPTS);
  localparam logic [CW-1:0] ACK_LIM = CW'(SHORT_ACK_LIMIT);
  localparam logic [CW-1:0] INV_LIM = CW'(INVALID_LIMIT);
  localparam logic [CW-1:0] TO_LIM  = CW'(TIMEOUT_LIMIT);
  localparam logic [CW-1:0] DF_LIM  = CW'(DEFER_LIMIT);
  localparam logic [CW-1:0] BD_LIM  = CW'(BR_DEFER_LIMIT);
  localparam logic [TIME_W-1:0] FLOOR_T = TIME_W'(DEFER_MS_FLOOR);
  localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(CLKS_PER_MS - 1);

  localparam logic [2:0] RES_OK      = 3'd0;
  localparam logic [2:0] RES_INVALID = 3'd1;
  localparam logic [2:0] RES_TIMEOUT = 3'd2;

  localparam logic [3:0] RPL_ACK      = 4'h0;
  localparam logic [3:0] RPL_DEFER    = 4'h2;
  localparam logic [3:0] RPL_BR_DEFER = 4'h8;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_PAUSE} state_t;
  typedef enum logic [1:0] {ACT_OK, ACT_FAIL, ACT_RETRY, ACT_PAUSE} act_t;

  state_t state_q;
  act_t   act;

  logic             rd_q;
  logic [LEN_W-1:0] len_q;
  logic [MS_W-1:0]  dms_q, pms_q;
  logic [CW-1:0]    att_q, ack_q, inv_q, to_q, dfr_q, bdf_q;
  logic [CW-1:0]    att_n, ack_n, inv_n, to_n, dfr_n, bdf_n;
  logic             flag_q, flag_n, rep_upd;
  logic [TIME_W-1:0] time_q, time_n;
  logic [PRE_W-1:0] pre_q;
  logic [MS_W-1:0]  ms_q;

  function automatic logic [TIME_W-1:0] sat_add(input logic [TIME_W-1:0] a,
                                                 input logic [MS_W-1:0] b);
    logic [TIME_W:0] s;
    s = {1'b0, a} + (TIME_W+1)'(b);
    return s[TIME_W] ? '1 : s[TIME_W-1:0];
  endfunction

  assign busy      = (state_q != S_IDLE);
  assign eng_start = (state_q == S_ISSUE);

  always_comb begin
    att_n   = att_q + CW'(1);
    ack_n   = ack_q;
    inv_n   = inv_q;
    to_n    = to_q;
    dfr_n   = dfr_q;
    bdf_n   = bdf_q;
    flag_n  = flag_q;
    time_n  = time_q;
    rep_upd = 1'b0;
    act     = ACT_FAIL;
    case (eng_result)
      RES_OK: begin
        to_n    = '0;
        inv_n   = '0;
        rep_upd = 1'b1;
        case (eng_reply)
          RPL_ACK: begin
            if (rd_q && (eng_bytes != len_q)) begin
              ack_n = ack_q + CW'(1);
              act   = (ack_n >= ACK_LIM) ? ACT_FAIL : ACT_RETRY;
            end else begin
              act = ACT_OK;
            end
          end
          RPL_DEFER: begin
            dfr_n  = dfr_q + CW'(1);
            time_n = sat_add(time_q, pms_q);
            if ((dfr_n >= DF_LIM) && (time_n >= FLOOR_T)) begin
              act = ACT_FAIL;
            end else begin
              act    = ACT_PAUSE;
              time_n = sat_add(time_n, dms_q);
            end
          end
          RPL_BR_DEFER: begin
            dfr_n  = '0;
            flag_n = 1'b1;
            bdf_n  = bdf_q + CW'(1);
            if (bdf_n >= BD_LIM) begin
              act = ACT_FAIL;
            end else begin
              act    = ACT_PAUSE;
              time_n = sat_add(time_q, dms_q);
            end
          end
          default: act = ACT_FAIL;
        endcase
      end
      RES_INVALID: begin
        inv_n = inv_q + CW'(1);
        act   = (inv_n >= INV_LIM) ? ACT_FAIL : ACT_RETRY;
      end
      RES_TIMEOUT: begin
        if (flag_q) begin
          dfr_n = dfr_q + CW'(1);
          if (dfr_n >= DF_LIM) begin
            act = ACT_FAIL;
          end else begin
            act    = ACT_PAUSE;
            time_n = sat_add(time_q, dms_q);
          end
        end else begin
          to_n = to_q + CW'(1);
          act  = (to_n >= TO_LIM) ? ACT_FAIL : ACT_RETRY;
        end
      end
      default: act = ACT_FAIL;
    endcase
    if (((act == ACT_RETRY) || (act == ACT_PAUSE)) && (att_n >= ATT_LIM))
      act = ACT_FAIL;
    if ((act == ACT_PAUSE) && (dms_q == '0))
      act = ACT_RETRY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      rd_q       <= 1'b0;
      len_q      <= '0;
      dms_q      <= '0;
      pms_q      <= '0;
      att_q      <= '0;
      ack_q      <= '0;
      inv_q      <= '0;
      to_q       <= '0;
      dfr_q      <= '0;
      bdf_q      <= '0;
      flag_q     <= 1'b0;
      time_q     <= '0;
      pre_q      <= '0;
      ms_q       <= '0;
      xfer_done  <= 1'b0;
      xfer_ok    <= 1'b0;
      last_reply <= '0;
    end else begin
      xfer_done <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            rd_q       <= req_read;
            len_q      <= req_len;
            dms_q      <= defer_ms;
            pms_q      <= poll_ms;
            att_q      <= '0;
            ack_q      <= '0;
            inv_q      <= '0;
            to_q       <= '0;
            dfr_q      <= '0;
            bdf_q      <= '0;
            flag_q     <= 1'b0;
            time_q     <= '0;
            xfer_ok    <= 1'b0;
            last_reply <= '0;
            state_q    <= S_ISSUE;
          end
        end
        S_ISSUE: state_q <= S_WAIT;
        S_WAIT: begin
          if (eng_done) begin
            att_q  <= att_n;
            ack_q  <= ack_n;
            inv_q  <= inv_n;
            to_q   <= to_n;
            dfr_q  <= dfr_n;
            bdf_q  <= bdf_n;
            flag_q <= flag_n;
            time_q <= time_n;
            if (rep_upd) last_reply <= eng_reply;
            case (act)
              ACT_OK: begin
                xfer_done <= 1'b1;
                xfer_ok   <= 1'b1;
                state_q   <= S_IDLE;
              end
              ACT_FAIL: begin
                xfer_done <= 1'b1;
                xfer_ok   <= 1'b0;
                state_q   <= S_IDLE;
              end
              ACT_RETRY: state_q <= S_ISSUE;
              default: begin
                pre_q   <= '0;
                ms_q    <= '0;
                state_q <= S_PAUSE;
              end
            endcase
          end
        end
        default: begin
          if (pre_q == PRE_LAST) begin
            pre_q <= '0;
            if (ms_q == dms_q - MS_W'(1)) state_q <= S_ISSUE;
            else ms_q <= ms_q + MS_W'(1);
          end else begin
            pre_q <= pre_q + PRE_W'(1);
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/sb_retry_ctrl_chk.sv
module sb_retry_ctrl_chk #(
  parameter int MAX_ATTEMPTS = 7
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       eng_start,
  input logic       eng_done,
  input logic [2:0] eng_result,
  input logic [3:0] eng_reply,
  input logic       xfer_done,
  input logic       xfer_ok
);

  logic [15:0] starts_q;
  logic        pending_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      starts_q  <= '0;
      pending_q <= 1'b0;
    end else begin
      if (!busy) starts_q <= '0;
      else if (eng_start) starts_q <= starts_q + 16'd1;
      if (eng_start) pending_q <= 1'b1;
      else if (eng_done) pending_q <= 1'b0;
    end
  end

  a_r1_attempt_cap: assert property (@(posedge clk) disable iff (!rst_n)
    starts_q <= 16'(MAX_ATTEMPTS));

  a_r11_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  a_r11_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> busy);

  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !busy);

  a_r9_nack_fatal: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && eng_done && eng_result == 3'd0 && eng_reply == 4'h1)
      |=> (xfer_done && !xfer_ok));

  a_r9_disconnect_fatal: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && eng_done && eng_result == 3'd3) |=> (xfer_done && !xfer_ok));

endmodule

bind sb_retry_ctrl sb_retry_ctrl_chk #(.MAX_ATTEMPTS(MAX_ATTEMPTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .eng_start(eng_start),
  .eng_done(eng_done), .eng_result(eng_result), .eng_reply(eng_reply),
  .xfer_done(xfer_done), .xfer_ok(xfer_ok)
);

// File: tb/tb_sb_retry_ctrl.sv
module tb_sb_retry_ctrl;
  localparam int CPM = 20;
  localparam int MAXA = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_read = 1'b0;
  logic [4:0] req_len = '0;
  logic [7:0] defer_ms = '0, poll_ms = '0;
  logic busy, eng_start, xfer_done, xfer_ok;
  logic eng_done = 1'b0;
  logic [2:0] eng_result = '0;
  logic [3:0] eng_reply = '0, last_reply;
  logic [4:0] eng_bytes = '0;

  always #10 clk = ~clk;

  sb_retry_ctrl #(.MAX_ATTEMPTS(MAXA), .CLKS_PER_MS(CPM)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
    .req_len(req_len), .defer_ms(defer_ms), .poll_ms(poll_ms), .busy(busy),
    .eng_start(eng_start), .eng_done(eng_done), .eng_result(eng_result),
    .eng_reply(eng_reply), .eng_bytes(eng_bytes), .xfer_done(xfer_done),
    .xfer_ok(xfer_ok), .last_reply(last_reply)
  );

  typedef struct { logic [2:0] res; logic [3:0] rep; logic [4:0] bytes; } rsp_t;
  typedef struct { logic ok; logic [3:0] rep; int att; int cyc; string tag; } exp_t;

  rsp_t rsp_q[$];
  exp_t exp_q[$];
  int vectors = 0, errors = 0, done_cnt = 0, mon_att = 0, mon_cyc = 0;
  bit reported = 0;

  task automatic check(input bit cond, input string tag, input int act, input int exp);
    vectors++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  task automatic rsp(input logic [2:0] res, input logic [3:0] rep, input logic [4:0] b, input int n);
    for (int i = 0; i < n; i++) rsp_q.push_back('{res, rep, b});
  endtask

  task automatic run(input bit rd, input int len, input int dms, input int pms,
                     input bit ok, input int rep, input int att, input int wait_ms,
                     input string tag);
    int d0;
    exp_q.push_back('{ok, 4'(rep), att, 3*att + CPM*wait_ms, tag});
    d0 = done_cnt;
    @(posedge clk); #2;
    req_valid = 1'b1; req_read = rd; req_len = 5'(len);
    defer_ms = 8'(dms); poll_ms = 8'(pms);
    @(posedge clk); #2;
    req_valid = 1'b0;
    while (done_cnt == d0) @(negedge clk);
    repeat (3) @(posedge clk);
    check(rsp_q.size() == 0, {tag, " script consumed"}, rsp_q.size(), 0);
    rsp_q.delete();
  endtask

  // engine model
  initial begin
    rsp_t r;
    forever begin
      @(posedge clk); #2;
      while (eng_start) begin
        if (rsp_q.size() == 0) begin
          r = '{3'd0, 4'h0, 5'd0};
          check(1'b0, "engine script underrun", 0, 1);
        end else r = rsp_q.pop_front();
        repeat (2) @(posedge clk); #2;
        eng_done = 1'b1; eng_result = r.res; eng_reply = r.rep; eng_bytes = r.bytes;
        @(posedge clk); #2;
        eng_done = 1'b0;
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) mon_cyc++;
      if (eng_start) mon_att++;
      if (xfer_done) begin
        if (exp_q.size() == 0) check(1'b0, "unexpected xfer_done", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          check(xfer_ok == e.ok, {e.tag, " ok"}, int'(xfer_ok), int'(e.ok));
          check(last_reply == e.rep, {e.tag, " last_reply"}, int'(last_reply), int'(e.rep));
          check(mon_att == e.att, {e.tag, " attempts"}, mon_att, e.att);
          check(mon_cyc == e.cyc, {e.tag, " busy cycles"}, mon_cyc, e.cyc);
        end
        mon_att = 0;
        mon_cyc = 0;
        done_cnt++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy, "R11 reset busy", int'(busy), 0);
    check(!eng_start, "R11 reset eng_start", int'(eng_start), 0);
    check(!xfer_done, "R11 reset xfer_done", int'(xfer_done), 0);
    check(!xfer_ok, "R11 reset xfer_ok", int'(xfer_ok), 0);
    check(last_reply == 4'h0, "R11 reset last_reply", int'(last_reply), 0);
    @(posedge clk); #2; rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R2 write ACK, byte count irrelevant
    rsp(3'd0, 4'h0, 5'd0, 1);
    run(0, 4, 0, 0, 1, 0, 1, 0, "R2 write ack");
    // R2 six short reads then full
    rsp(3'd0, 4'h0, 5'd2, 6); rsp(3'd0, 4'h0, 5'd4, 1);
    run(1, 4, 0, 0, 1, 0, 7, 0, "R2 short then full");
    // R2 seven short reads fail
    rsp(3'd0, 4'h0, 5'd1, 7);
    run(1, 4, 0, 0, 0, 0, 7, 0, "R2 short limit");
    // R3 invalid limit
    rsp(3'd1, 4'h0, 5'd0, 2);
    run(0, 4, 0, 0, 0, 0, 2, 0, "R3 invalid limit");
    // R4 timeout limit, no wait even with defer_ms set (R10)
    rsp(3'd2, 4'h0, 5'd0, 3);
    run(0, 4, 4, 0, 0, 0, 3, 0, "R4 timeout limit no wait");
    // R8 success clears timeout count
    rsp(3'd2, 4'h0, 5'd0, 2); rsp(3'd0, 4'h0, 5'd3, 1);
    rsp(3'd2, 4'h0, 5'd0, 2); rsp(3'd0, 4'h0, 5'd4, 1);
    run(1, 4, 0, 0, 1, 0, 6, 0, "R8 timeout count cleared");
    // R8 success clears invalid count
    rsp(3'd1, 4'h0, 5'd0, 1); rsp(3'd0, 4'h0, 5'd3, 1);
    rsp(3'd1, 4'h0, 5'd0, 1); rsp(3'd0, 4'h0, 5'd4, 1);
    run(1, 4, 0, 0, 1, 0, 4, 0, "R8 invalid count cleared");
    // R9 terminal outcomes
    rsp(3'd0, 4'h1, 5'd0, 1);
    run(0, 4, 0, 0, 0, 1, 1, 0, "R9 nack");
    rsp(3'd0, 4'h4, 5'd0, 1);
    run(0, 4, 0, 0, 0, 4, 1, 0, "R9 bridged nack");
    rsp(3'd3, 4'h0, 5'd0, 1);
    run(0, 4, 0, 0, 0, 0, 1, 0, "R9 disconnect");
    rsp(3'd4, 4'h0, 5'd0, 1);
    run(0, 4, 0, 0, 0, 0, 1, 0, "R9 acquire");
    rsp(3'd6, 4'h0, 5'd0, 1);
    run(0, 4, 0, 0, 0, 0, 1, 0, "R9 unknown result");
    // R5 count and time floor both met: fail on 7th, six 1 ms waits (R10)
    rsp(3'd0, 4'h2, 5'd0, 7);
    run(0, 4, 1, 8, 0, 2, 7, 6, "R5 defer exit");
    // R5 time below floor: keep going past 7
    rsp(3'd0, 4'h2, 5'd0, 7); rsp(3'd0, 4'h0, 5'd0, 1);
    run(0, 4, 1, 1, 1, 0, 8, 7, "R5 defer time short");
    // R6 bridged defer limit, 2 ms waits
    rsp(3'd0, 4'h8, 5'd0, 7);
    run(0, 4, 2, 0, 0, 8, 7, 12, "R6 bridged limit");
    // R6 bridged defer clears native count
    rsp(3'd0, 4'h2, 5'd0, 6); rsp(3'd0, 4'h8, 5'd0, 1);
    rsp(3'd0, 4'h2, 5'd0, 2); rsp(3'd0, 4'h0, 5'd0, 1);
    run(0, 4, 0, 10, 1, 0, 10, 0, "R6 native count cleared");
    // R7 timeouts after bridged defer use defer budget and wait
    rsp(3'd0, 4'h8, 5'd0, 1); rsp(3'd2, 4'h0, 5'd0, 4); rsp(3'd0, 4'h0, 5'd0, 1);
    run(0, 4, 1, 0, 1, 0, 6, 5, "R7 timeout as defer");
    // R1 global cap
    for (int i = 0; i < 5; i++) begin
      rsp(3'd1, 4'h0, 5'd0, 1); rsp(3'd0, 4'h0, 5'd1, 1);
    end
    run(1, 4, 0, 0, 0, 0, 10, 0, "R1 attempt cap");

    check(exp_q.size() == 0, "R11 all transfers finished", exp_q.size(), 0);
    report();
  end
endmodule